// File: doc/BRIEF.md
# Interrupt Cause Vector Router

The router gathers the interrupt events of four internal sources (command queue, fault queue, page-request queue and performance monitor), records each as a sticky pending bit, and sends every pending cause to a vector number that software assigns. One control bit picks the delivery style. In wired mode each vector drives its own output line toward a platform interrupt controller. In message mode each vector raises a request to a downstream message sender. That sender holds the address/data table and its per-vector mask bits, and it performs the memory write.

Software reaches the block through a small 32-bit register port. A vector-assignment register holds one 4-bit field per cause. Only the low `VEC_BITS` bits of each field are stored. Software writes all-ones and reads the field back to learn how many vectors exist (2^`VEC_BITS`). Several causes may share one vector. A pending register clears with write-1, and a control register holds the delivery mode. Every request gets a response one cycle later. An illegal access returns an error and changes nothing.

The message request per vector is a valid/ready pair (`msg_req`/`msg_ack`). Once raised, a request stays high, whatever the mask does, until the cycle in which `msg_ack` is high. The sender may stall it for any number of cycles.

Top module: `irq_vec_router`

## Requirements
- R1: After reset the vector, pending and control registers read 0, the block is in message mode, and `msg_req`, `wire_irq` and `rsp_valid` are 0.
- R2: Register word 0 (byte offset 0x0) holds the vector fields: command queue in bits 3:0, fault queue in bits 7:4, page-request queue in bits 11:8, performance monitor in bits 15:12. In each field only the low `VEC_BITS` bits are kept. The other field bits and bits 31:16 read 0, so writing 0xFFFF reads back 0x3333 when `VEC_BITS`=2.
- R3: Register word 1 (offset 0x4) holds one pending bit per cause, using the bit order of `src_evt`: bit 0 command queue, 1 fault queue, 2 page-request queue, 3 performance monitor. A high `src_evt` bit sets its pending bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R4: A source event in the same cycle as a write-1 to clear the same pending bit leaves the bit set.
- R5: Register word 2 (offset 0x8), bit 0, selects wired mode when 1 and message mode when 0. Its other bits read 0.
- R6: In wired mode, `wire_irq[v]` is the OR of all pending causes whose field equals v. It rises on the clock edge that samples the event, stays high while any such cause is pending, and falls on the edge that clears the last one. In message mode `wire_irq` is 0.
- R7: In message mode, a pending bit that goes from 0 to 1 for a cause mapped to v raises `msg_req[v]` on the second clock edge after the event is sampled. The request holds until the edge on which `msg_ack[v]` is high, and that edge drops it. Wired mode issues no new request.
- R8: While `msg_mask[v]` is high, a new request for v is held back. The edge after the mask falls raises exactly one request.
- R9: Causes that share a vector and become pending before that vector's request is raised merge into a single request.
- R10: Every request gets `rsp_valid` exactly one cycle later. An access that is not 32 bits wide (`req_size` 0=byte, 1=half, 2=word, 3=double), is not aligned to 4 bytes, or addresses word 3 returns `rsp_err`=1 with `rsp_rdata`=0, and it changes no register. Writes return data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Byte address of the access |
| req_size | input | 2 | Access width code: 0 byte, 1 half, 2 word, 3 double |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access rejected |
| src_evt | input | 4 | Per-cause event pulses (bit order as R3) |
| msg_mask | input | 2^VEC_BITS (4) | Per-vector mask from the message table |
| msg_req | output | 2^VEC_BITS (4) | Per-vector message request (valid) |
| msg_ack | input | 2^VEC_BITS (4) | Per-vector message acceptance (ready) |
| wire_irq | output | 2^VEC_BITS (4) | Per-vector wired interrupt lines |

## Verification
Pending bits, the register response and `wire_irq` are all due right after the edge that samples the request or event. A message request is due one edge later, and an acknowledged request drops on the acknowledging edge. The bench drives every input on the falling edge and reads results on the following falling edge. For message requests it waits one further falling edge, and it checks that `msg_req` is still low at the intermediate point, so a request that is one cycle early or late is reported. Held-back and merged requests are checked over several idle cycles after the acknowledge, to show that no second request appears.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NCAUSE  = 4;
  localparam int FIELD_W = 4;
  localparam int DATA_W  = 32;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  localparam int W_VEC  = 0;
  localparam int W_PEND = 1;
  localparam int W_CTRL = 2;
endpackage

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
  import irq_router_pkg::*;
#(
  parameter int VEC_BITS = 2,
  parameter int ADDR_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic                             req_write,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic [1:0]                       req_size,
  input  logic [DATA_W-1:0]                req_wdata,
  input  logic [NCAUSE-1:0]                src_evt,
  output logic                             rsp_valid,
  output logic [DATA_W-1:0]                rsp_rdata,
  output logic                             rsp_err,
  output logic [NCAUSE-1:0][VEC_BITS-1:0]  vec_o,
  output logic [NCAUSE-1:0]                pend_o,
  output logic [NCAUSE-1:0]                new_set_o,
  output logic                             wired_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]               word;
  logic                            sel_vec, sel_pend, sel_ctrl, acc_ok, do_wr;
  logic [NCAUSE-1:0][VEC_BITS-1:0] vec_q;
  logic [NCAUSE-1:0]               pend_q, clr, pend_d;
  logic                            wired_q;
  logic [DATA_W-1:0]               rd_comb;
  logic                            unused_wdata;

  assign word     = req_addr[ADDR_W-1:2];
  assign sel_vec  = (word == WORD_W'(W_VEC));
  assign sel_pend = (word == WORD_W'(W_PEND));
  assign sel_ctrl = (word == WORD_W'(W_CTRL));
  assign acc_ok   = req_valid && (req_size == SZ_WORD) && (req_addr[1:0] == 2'b00)
                    && (sel_vec || sel_pend || sel_ctrl);
  assign do_wr    = acc_ok && req_write;
  assign unused_wdata = ^req_wdata;

  assign clr       = (do_wr && sel_pend) ? req_wdata[NCAUSE-1:0] : '0;
  assign pend_d    = (pend_q & ~clr) | src_evt;
  assign new_set_o = src_evt & ~pend_q;

  always_comb begin
    rd_comb = '0;
    if (sel_vec) begin
      for (int c = 0; c < NCAUSE; c++) rd_comb[c*FIELD_W +: VEC_BITS] = vec_q[c];
    end else if (sel_pend) begin
      rd_comb[NCAUSE-1:0] = pend_q;
    end else if (sel_ctrl) begin
      rd_comb[0] = wired_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q     <= '0;
      pend_q    <= '0;
      wired_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !acc_ok;
      rsp_rdata <= (acc_ok && !req_write) ? rd_comb : '0;
      if (do_wr && sel_vec) begin
        for (int c = 0; c < NCAUSE; c++) vec_q[c] <= req_wdata[c*FIELD_W +: VEC_BITS];
      end
      if (do_wr && sel_ctrl) wired_q <= req_wdata[0];
    end
  end

  assign vec_o   = vec_q;
  assign pend_o  = pend_q;
  assign wired_o = wired_q;
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map
  import irq_router_pkg::*;
#(
  parameter int VEC_BITS = 2,
  localparam int NVEC    = 1 << VEC_BITS
) (
  input  logic [NCAUSE-1:0][VEC_BITS-1:0] vec_i,
  input  logic [NCAUSE-1:0]               pend_i,
  input  logic [NCAUSE-1:0]               new_set_i,
  input  logic                            wired_i,
  output logic [NVEC-1:0]                 wire_irq_o,
  output logic [NVEC-1:0]                 vec_new_o
);
  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    localparam logic [VEC_BITS-1:0] VID = VEC_BITS'(v);
    logic any_pend, any_new;
    always_comb begin
      any_pend = 1'b0;
      any_new  = 1'b0;
      for (int c = 0; c < NCAUSE; c++) begin
        if (vec_i[c] == VID) begin
          any_pend = any_pend | pend_i[c];
          any_new  = any_new  | new_set_i[c];
        end
      end
    end
    assign wire_irq_o[v] = wired_i & any_pend;
    assign vec_new_o[v]  = ~wired_i & any_new;
  end
endmodule

// File: rtl/irq_msg_issue.sv
module irq_msg_issue #(
  parameter int NVEC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] vec_new_i,
  input  logic [NVEC-1:0] mask_i,
  input  logic [NVEC-1:0] ack_i,
  output logic [NVEC-1:0] req_o
);
  for (genvar v = 0; v < NVEC; v++) begin : g_slot
    logic want_q, iss_q, launch;
    assign launch = want_q & ~mask_i[v] & ~iss_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        want_q <= 1'b0;
        iss_q  <= 1'b0;
      end else begin
        want_q <= (want_q & ~launch) | vec_new_i[v];
        iss_q  <= (iss_q & ~ack_i[v]) | launch;
      end
    end
    assign req_o[v] = iss_q;
  end
endmodule

// File: rtl/irq_vec_router.sv
module irq_vec_router
  import irq_router_pkg::*;
#(
  parameter int VEC_BITS = 2,
  parameter int ADDR_W   = 4,
  localparam int NVEC    = 1 << VEC_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic                 rsp_err,
  input  logic [3:0]           src_evt,
  input  logic [NVEC-1:0]      msg_mask,
  output logic [NVEC-1:0]      msg_req,
  input  logic [NVEC-1:0]      msg_ack,
  output logic [NVEC-1:0]      wire_irq
);
  logic [NCAUSE-1:0][VEC_BITS-1:0] vec_q;
  logic [NCAUSE-1:0]               pend_q, new_set;
  logic                            wired_q;
  logic [NVEC-1:0]                 vec_new;

  irq_cause_regs #(.VEC_BITS(VEC_BITS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .src_evt(src_evt),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .vec_o(vec_q), .pend_o(pend_q), .new_set_o(new_set), .wired_o(wired_q)
  );

  irq_vec_map #(.VEC_BITS(VEC_BITS)) u_map (
    .vec_i(vec_q), .pend_i(pend_q), .new_set_i(new_set), .wired_i(wired_q),
    .wire_irq_o(wire_irq), .vec_new_o(vec_new)
  );

  irq_msg_issue #(.NVEC(NVEC)) u_issue (
    .clk(clk), .rst_n(rst_n), .vec_new_i(vec_new), .mask_i(msg_mask),
    .ack_i(msg_ack), .req_o(msg_req)
  );
endmodule

// File: rtl/irq_vec_router_chk.sv
module irq_vec_router_chk #(
  parameter int VEC_BITS = 2,
  localparam int NVEC    = 1 << VEC_BITS
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [31:0]     rsp_rdata,
  input logic [3:0]      src_evt,
  input logic [3:0]      pend_q,
  input logic [NVEC-1:0] wire_irq,
  input logic [NVEC-1:0] msg_req,
  input logic [NVEC-1:0] msg_ack,
  input logic [NVEC-1:0] msg_mask
);
  // R4
  evt_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> (($past(src_evt) & ~pend_q) == 4'b0));

  // R6
  wire_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wire_irq) |-> (|pend_q));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(msg_req & ~msg_ack)) |=> (($past(msg_req & ~msg_ack) & ~msg_req) == '0));

  // R8
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|msg_mask) |=> ((msg_req & ~$past(msg_req) & $past(msg_mask)) == '0));

  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R10
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'b0));
endmodule

bind irq_vec_router irq_vec_router_chk #(.VEC_BITS(VEC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .src_evt(src_evt), .pend_q(pend_q),
  .wire_irq(wire_irq), .msg_req(msg_req), .msg_ack(msg_ack), .msg_mask(msg_mask)
);

// File: tb/irq_vec_router_tb.sv
`timescale 1ns/1ps
module irq_vec_router_tb;
  localparam int NV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  src_evt = '0;
  logic [NV-1:0] msg_mask = '0, msg_ack = '0, msg_req, wire_irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  irq_vec_router u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .src_evt(src_evt), .msg_mask(msg_mask), .msg_req(msg_req),
    .msg_ack(msg_ack), .wire_irq(wire_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, input logic [3:0] ev,
                     output logic [31:0] rd, output logic er, output logic vl);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_wdata = wd; src_evt = ev;
    @(negedge clk);
    req_valid = 1'b0; src_evt = '0;
    rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
  endtask

  task automatic wr32(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er, vl;
    acc(1'b1, a, 2'd2, d, 4'h0, rd, er, vl);
  endtask

  task automatic rd32(input logic [3:0] a, output logic [31:0] d);
    logic er, vl;
    acc(1'b0, a, 2'd2, 32'h0, 4'h0, d, er, vl);
  endtask

  task automatic pulse(input logic [3:0] ev);
    @(negedge clk); src_evt = ev;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic ack_all();
    msg_ack = '1;
    @(negedge clk);
    msg_ack = '0;
  endtask

  function automatic logic [3:0] map_vec(input logic [15:0] v, input logic [3:0] p);
    logic [3:0] r = '0;
    for (int c = 0; c < 4; c++) if (p[c]) r[(v >> (4*c)) & 16'h3] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, rv;
    logic er, vl;
    logic [15:0] vv;
    logic [3:0] ev, clr;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    chk("R1 msg_req in reset", {28'h0, msg_req}, 32'h0);
    chk("R1 wire_irq in reset", {28'h0, wire_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
    rd32(4'h0, rd); chk("R1 vec reset", rd, 32'h0);
    rd32(4'h4, rd); chk("R1 pend reset", rd, 32'h0);
    rd32(4'h8, rd); chk("R1 ctrl reset", rd, 32'h0);

    // R2 discovery of implemented bits
    wr32(4'h0, 32'hFFFF_FFFF);
    rd32(4'h0, rd); chk("R2 all-ones readback", rd, 32'h0000_3333);
    wr32(4'h0, 32'h0000_1B2D);
    rd32(4'h0, rd); chk("R2 partial field readback", rd, 32'h0000_1321);

    // R5
    wr32(4'h8, 32'hFFFF_FFFE);
    rd32(4'h8, rd); chk("R5 ctrl bit0 clear", rd, 32'h0);
    wr32(4'h8, 32'hFFFF_FFFF);
    rd32(4'h8, rd); chk("R5 ctrl readback", rd, 32'h1);

    // R10 illegal accesses
    acc(1'b1, 4'h1, 2'd2, 32'h0, 4'h0, rd, er, vl);
    chk("R10 misaligned err", {30'h0, vl, er}, 32'h3);
    acc(1'b1, 4'h0, 2'd0, 32'h0, 4'h0, rd, er, vl);
    chk("R10 byte size err", {30'h0, vl, er}, 32'h3);
    acc(1'b1, 4'h0, 2'd3, 32'h0, 4'h0, rd, er, vl);
    chk("R10 double size err", {30'h0, vl, er}, 32'h3);
    acc(1'b0, 4'hC, 2'd2, 32'h0, 4'h0, rd, er, vl);
    chk("R10 unmapped err", {30'h0, vl, er}, 32'h3);
    chk("R10 err data zero", rd, 32'h0);
    acc(1'b0, 4'h2, 2'd2, 32'h0, 4'h0, rd, er, vl);
    chk("R10 misaligned read data", rd, 32'h0);
    rd32(4'h0, rd); chk("R10 vec unchanged after errors", rd, 32'h0000_1321);
    acc(1'b0, 4'h0, 2'd2, 32'h0, 4'h0, rd, er, vl);
    chk("R10 good read no err", {30'h0, vl, er}, 32'h2);

    // R6 wired mode, random mappings and events
    for (int i = 0; i < 40; i++) begin
      rv = $urandom;
      vv = rv[15:0] & 16'h3333;
      wr32(4'h0, rv);
      wr32(4'h4, 32'hF);
      ev = 4'($urandom);
      pulse(ev);
      chk("R6 wire after event", {28'h0, wire_irq}, {28'h0, map_vec(vv, ev)});
      repeat (2) @(negedge clk);
      chk("R6 wire held", {28'h0, wire_irq}, {28'h0, map_vec(vv, ev)});
      chk("R7 no msg in wired mode", {28'h0, msg_req}, 32'h0);
      rd32(4'h4, rd); chk("R3 pend readback", rd, {28'h0, ev});
      clr = 4'($urandom);
      wr32(4'h4, {28'h0, clr});
      chk("R6 wire after partial clear", {28'h0, wire_irq}, {28'h0, map_vec(vv, ev & ~clr)});
    end

    // R3 write 0 keeps, R4 event beats clear
    wr32(4'h4, 32'hF);
    pulse(4'h2);
    wr32(4'h4, 32'h0);
    rd32(4'h4, rd); chk("R3 write zero keeps", rd, 32'h2);
    pulse(4'h1);
    acc(1'b1, 4'h4, 2'd2, 32'h1, 4'h1, rd, er, vl);
    rd32(4'h4, rd); chk("R4 event with clear stays set", rd, 32'h3);
    wr32(4'h4, 32'h1);
    rd32(4'h4, rd); chk("R3 w1c clears", rd, 32'h2);

    // R7 message mode, random
    wr32(4'h8, 32'h0);
    for (int i = 0; i < 40; i++) begin
      rv = $urandom;
      vv = rv[15:0] & 16'h3333;
      wr32(4'h0, rv);
      wr32(4'h4, 32'hF);
      ev = 4'(($urandom % 15) + 1);
      pulse(ev);
      chk("R7 not yet after one edge", {28'h0, msg_req}, 32'h0);
      chk("R6 no wire in msg mode", {28'h0, wire_irq}, 32'h0);
      @(negedge clk);
      chk("R7 request raised", {28'h0, msg_req}, {28'h0, map_vec(vv, ev)});
      repeat (2) @(negedge clk);
      chk("R7 request held", {28'h0, msg_req}, {28'h0, map_vec(vv, ev)});
      ack_all();
      chk("R7 dropped on ack", {28'h0, msg_req}, 32'h0);
    end

    // R8 masked vector
    wr32(4'h0, 32'h0000_0001);
    wr32(4'h4, 32'hF);
    msg_mask = 4'b0010;
    pulse(4'h1);
    repeat (4) @(negedge clk);
    chk("R8 masked held back", {28'h0, msg_req}, 32'h0);
    msg_mask = 4'b0000;
    @(negedge clk);
    chk("R8 one request on unmask", {28'h0, msg_req}, 32'h2);
    ack_all();
    repeat (3) @(negedge clk);
    chk("R8 no second request", {28'h0, msg_req}, 32'h0);

    // R9 shared vector merge
    wr32(4'h0, 32'h0000_0022);
    wr32(4'h4, 32'hF);
    pulse(4'h3);
    @(negedge clk);
    chk("R9 shared vector request", {28'h0, msg_req}, 32'h4);
    ack_all();
    repeat (3) @(negedge clk);
    chk("R9 merged single request", {28'h0, msg_req}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule